// File: doc/BRIEF.md
# Page-Organised NAND Flash Front-End Emulator

This block is a synthesizable stand-in for a small NAND flash device. A host drives it over one shared 8-bit bus, and the strobe lines decide what each byte means. A byte is a command when the command-latch input is high and an address byte when the address-latch input is high. With both low it is page data. Each byte is taken on the rising edge of the active-low write strobe. Read data leaves through an output byte with an enable, one byte per read-strobe cycle. An active-low ready/busy output models the open-drain line that external logic would wire-AND.

Inside there is an on-chip byte array organised as blocks of pages, and a page register that is one page wide. Page read, page program and block erase each hold the device busy for a parameterised number of clock cycles. During that window the byte transfers between the array and the page register take place. Programming can only clear bits. Erase sets a whole block back to 0xFF. Copy-back moves a page from the array to another page through the page register, with no data entry phase. The emulator also provides a status byte and a fixed four-byte identification sequence. Write protection blocks program and erase. Chip enable may be released in the middle of a read-out without losing the read position.

All inputs are synchronous to `clk`. Strobe edges are found by comparing each strobe with its value one clock earlier.

Top module: `nand_emu`

## Requirements
- R1: With `ceN` low, a rising edge of `weN` captures `ioIn` as a command if `cleIn`=1 and `aleIn`=0, as an address byte if `aleIn`=1 and `cleIn`=0, and as a data byte if both are 0.
- R2: The read, program and copy-back commands take four address bytes in this order: column low, column high, row low, row high. Erase takes two: row low, row high. Address bytes beyond that count are ignored.
- R3: Command 0x00, then an address, then 0x30 loads the addressed page into the page register during a busy window of READ_CYCLES. After that, every rising edge of `reN` moves to the next column, starting at the given column. A column past the page returns 0xFF.
- R4: Command 0x80 fills the page register with 0xFF. After the address, each data byte goes to the next column. Confirm 0x10 then writes (old AND register) into every byte of the page.
- R5: Command 0x60, two row bytes and 0xD0 set every byte of the block that holds the row to 0xFF, and leave the other blocks unchanged.
- R6: `rbN` is low for exactly READ_CYCLES, PROG_CYCLES or ERASE_CYCLES clocks after the confirm byte is captured, and high at all other times.
- R7: Command 0x70 selects the status byte. It is accepted while busy. Bit 6 is 1 when ready, bit 0 is 1 when the last program or erase was refused, and bit 7 follows `wpN`. All other bits are 0.
- R8: While busy, every command except 0x70 is ignored, and so are address and data bytes.
- R9: Command 0x90 makes the following read cycles return the identification bytes 0xC2, 0x5A, 0x01 and 0x15, in that order.
- R10: When `wpN` is low at a program or erase confirm, the operation is refused: `rbN` stays high, the array is unchanged and status bit 0 is set. A later accepted program or erase clears that bit.
- R11: With `ceN` high, strobe edges are ignored and `ioOe` is 0. The read position is kept across `ceN` high periods.
- R12: Command 0x00, an address and then 0x35 loads the page register the same way 0x30 does, and the register can be read out afterwards. Command 0x85, an address and then 0x10 programs the register into the new page without any data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; the array returns to 0xFF |
| ceN | input | 1 | Active-low chip enable |
| cleIn | input | 1 | Command-latch strobe level |
| aleIn | input | 1 | Address-latch strobe level |
| weN | input | 1 | Active-low write strobe; the byte is taken on its rising edge |
| reN | input | 1 | Active-low read strobe; the position advances on its rising edge |
| wpN | input | 1 | Active-low write protect |
| ioIn | input | 8 | Bus byte from the host |
| ioOut | output | 8 | Bus byte to the host |
| ioOe | output | 1 | Output enable for `ioOut` |
| rbN | output | 1 | Ready (1) / busy (0) |

## Verification
The assertions assume that `cleIn` and `aleIn` are never high together on a write-strobe edge. They also assume that a strobe stays low for at least one sampled clock, so that each edge is seen exactly once. The bench drives every strobe from the falling clock edge. Each strobe is held low for a full cycle, and the latch levels are held steady around it. The bench issues confirm commands only after the full address has been given. The busy-time parameters are assumed to be at least the number of bytes moved per operation, and the default values meet that.

// File: rtl/nand_pkg.sv
package nand_pkg;
  localparam logic [7:0] CMD_READ     = 8'h00;
  localparam logic [7:0] CMD_READ_GO  = 8'h30;
  localparam logic [7:0] CMD_CB_GO    = 8'h35;
  localparam logic [7:0] CMD_PROG     = 8'h80;
  localparam logic [7:0] CMD_CB_PROG  = 8'h85;
  localparam logic [7:0] CMD_PROG_GO  = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO = 8'hD0;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_ID       = 8'h90;

  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_PROG, OP_ERASE} opKind_t;
  typedef enum logic [1:0] {OUT_DATA, OUT_STAT, OUT_ID} outMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic        regFill;
    logic        regWr;
    logic        colLoad;
    logic        colInc;
    logic        idClr;
    logic        idInc;
    logic        xRead;
    logic        xProg;
    logic        xErase;
    logic [15:0] xIdx;
    logic [15:0] colVal;
    logic [15:0] row;
    outMode_t    outMode;
    logic [7:0]  status;
  } dpCtl_t;
endpackage

// File: rtl/nand_ctrl.sv
module nand_ctrl
  import nand_pkg::*;
#(
  parameter int PAGE_BYTES   = 16,
  parameter int BLOCK_BYTES  = 64,
  parameter int READ_CYCLES  = 20,
  parameter int PROG_CYCLES  = 40,
  parameter int ERASE_CYCLES = 80
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       cleIn,
  input  logic       aleIn,
  input  logic       weN,
  input  logic       reN,
  input  logic       wpN,
  input  logic [7:0] ioIn,
  output dpCtl_t     ctl,
  output logic       busy
);
  localparam int MAXC = (ERASE_CYCLES > PROG_CYCLES)
                        ? ((ERASE_CYCLES > READ_CYCLES) ? ERASE_CYCLES : READ_CYCLES)
                        : ((PROG_CYCLES > READ_CYCLES) ? PROG_CYCLES : READ_CYCLES);
  localparam int CW = $clog2(MAXC + 1);

  logic          weQ, reQ, busyQ, failQ;
  logic [CW-1:0] opCnt, opLen;
  opKind_t       opKind, pendOp;
  outMode_t      outQ;
  logic [2:0]    addrCnt, addrNeed;
  logic [7:0]    colLo, rowLo;
  logic [15:0]   rowQ;
  logic          weRise, reRise, cmdStb, addrStb, dataStb, cmdGood, addrOk, dataOk;
  logic          addrDone;

  assign weRise   = !weQ && weN && !ceN;
  assign reRise   = !reQ && reN && !ceN;
  assign cmdStb   = weRise && cleIn && !aleIn;
  assign addrStb  = weRise && aleIn && !cleIn;
  assign dataStb  = weRise && !cleIn && !aleIn;
  assign cmdGood  = cmdStb && (!busyQ || ioIn == CMD_STATUS);
  assign addrDone = (addrCnt == addrNeed);
  assign addrOk   = addrStb && !busyQ && pendOp != OP_NONE && addrCnt < addrNeed;
  assign dataOk   = dataStb && !busyQ && pendOp == OP_PROG && addrDone;
  assign busy     = busyQ;

  always_comb begin
    ctl         = '0;
    ctl.row     = rowQ;
    ctl.outMode = outQ;
    ctl.status  = {wpN, !busyQ, 5'b0, failQ};
    ctl.xIdx    = 16'(opCnt);
    ctl.xRead   = busyQ && opKind == OP_READ  && 32'(opCnt) < PAGE_BYTES;
    ctl.xProg   = busyQ && opKind == OP_PROG  && 32'(opCnt) < PAGE_BYTES;
    ctl.xErase  = busyQ && opKind == OP_ERASE && 32'(opCnt) < BLOCK_BYTES;
    ctl.regFill = cmdGood && ioIn == CMD_PROG;
    ctl.idClr   = cmdGood && ioIn == CMD_ID;
    ctl.regWr   = dataOk;
    ctl.colInc  = dataOk || (reRise && !busyQ && outQ == OUT_DATA);
    ctl.idInc   = reRise && !busyQ && outQ == OUT_ID;
    ctl.colLoad = addrOk && addrNeed == 3'd4 && addrCnt == 3'd1;
    ctl.colVal  = {ioIn, colLo};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weQ <= 1'b1; reQ <= 1'b1; busyQ <= 1'b0; failQ <= 1'b0;
      opCnt <= '0; opLen <= '0; opKind <= OP_NONE; pendOp <= OP_NONE;
      outQ <= OUT_DATA; addrCnt <= '0; addrNeed <= '0;
      colLo <= '0; rowLo <= '0; rowQ <= '0;
    end else begin
      weQ <= weN;
      reQ <= reN;
      if (cmdGood) begin
        case (ioIn)
          CMD_READ: begin
            pendOp <= OP_READ; addrNeed <= 3'd4; addrCnt <= '0; outQ <= OUT_DATA;
          end
          CMD_PROG, CMD_CB_PROG: begin
            pendOp <= OP_PROG; addrNeed <= 3'd4; addrCnt <= '0;
          end
          CMD_ERASE: begin
            pendOp <= OP_ERASE; addrNeed <= 3'd2; addrCnt <= '0;
          end
          CMD_STATUS: outQ <= OUT_STAT;
          CMD_ID: begin
            outQ <= OUT_ID; pendOp <= OP_NONE;
          end
          CMD_READ_GO, CMD_CB_GO: begin
            if (pendOp == OP_READ && addrDone) begin
              busyQ <= 1'b1; opKind <= OP_READ; opLen <= CW'(READ_CYCLES);
              opCnt <= '0; pendOp <= OP_NONE; outQ <= OUT_DATA;
            end
          end
          CMD_PROG_GO, CMD_ERASE_GO: begin
            if ((ioIn == CMD_PROG_GO && pendOp == OP_PROG && addrDone) ||
                (ioIn == CMD_ERASE_GO && pendOp == OP_ERASE && addrDone)) begin
              pendOp <= OP_NONE;
              if (wpN) begin
                busyQ  <= 1'b1; failQ <= 1'b0; opCnt <= '0;
                opKind <= pendOp;
                opLen  <= (pendOp == OP_PROG) ? CW'(PROG_CYCLES) : CW'(ERASE_CYCLES);
              end else begin
                failQ <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
      if (addrOk) begin
        addrCnt <= addrCnt + 3'd1;
        if (addrNeed == 3'd4 && addrCnt == 3'd0) colLo <= ioIn;
        if (addrCnt == addrNeed - 3'd2) rowLo <= ioIn;
        if (addrCnt == addrNeed - 3'd1) rowQ <= {ioIn, rowLo};
      end
      if (busyQ) begin
        if (opCnt == opLen - CW'(1)) begin
          busyQ <= 1'b0; opKind <= OP_NONE;
        end else begin
          opCnt <= opCnt + CW'(1);
        end
      end
    end
  end

  // R2: the address count never runs past what the command needs
  p_addr_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    addrCnt <= addrNeed);
  // R8: a non-status command while busy leaves the pending command and output selection alone
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && cmdStb && ioIn != CMD_STATUS) |=> (pendOp == $past(pendOp) && outQ == $past(outQ)));
  // R10: with write protect low and the device idle, no program or erase can start
  p_wp_block_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!wpN && !busyQ) |=> !(busyQ && opKind != OP_READ));
  // R7: a status command is taken even while busy
  p_status_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStb && busyQ && ioIn == CMD_STATUS) |=> outQ == OUT_STAT);
  // R6: the busy counter stays inside its window
  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> opCnt < opLen);
endmodule

// File: rtl/nand_dp.sv
module nand_dp
  import nand_pkg::*;
#(
  parameter int          PAGE_BYTES      = 16,
  parameter int          PAGES           = 16,
  parameter int          PAGES_PER_BLOCK = 4,
  parameter logic [31:0] ID_CODE         = 32'hC25A0115
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       reN,
  input  logic [7:0] ioIn,
  input  dpCtl_t     ctl,
  output logic [7:0] ioOut,
  output logic       ioOe
);
  localparam int ARRAY_BYTES = PAGES * PAGE_BYTES;
  localparam int BLOCK_BYTES = PAGES_PER_BLOCK * PAGE_BYTES;
  localparam int AW          = $clog2(ARRAY_BYTES);
  localparam int PW          = $clog2(PAGE_BYTES);

  logic [7:0]    mem     [ARRAY_BYTES];
  logic [7:0]    pageReg [PAGE_BYTES];
  logic [15:0]   colPtr;
  logic [1:0]    idPtr;
  logic [AW-1:0] memAddr;
  logic [PW-1:0] xByte;
  logic [7:0]    memQ;
  int            rowI;

  always_comb begin
    rowI = int'(ctl.row) % PAGES;
    if (ctl.xErase)
      memAddr = AW'((rowI / PAGES_PER_BLOCK) * BLOCK_BYTES + int'(ctl.xIdx));
    else
      memAddr = AW'(rowI * PAGE_BYTES + int'(ctl.xIdx));
  end
  assign xByte = PW'(ctl.xIdx);
  assign memQ  = mem[memAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ARRAY_BYTES; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE_BYTES; i++) pageReg[i] <= 8'hFF;
      colPtr <= '0;
      idPtr  <= '0;
    end else begin
      if (ctl.regFill)
        for (int i = 0; i < PAGE_BYTES; i++) pageReg[i] <= 8'hFF;
      if (ctl.regWr && 32'(colPtr) < PAGE_BYTES) pageReg[PW'(colPtr)] <= ioIn;
      if (ctl.xRead)  pageReg[xByte] <= memQ;
      if (ctl.xProg)  mem[memAddr] <= memQ & pageReg[xByte];
      if (ctl.xErase) mem[memAddr] <= 8'hFF;
      if (ctl.colLoad)     colPtr <= ctl.colVal;
      else if (ctl.colInc) colPtr <= colPtr + 16'd1;
      if (ctl.idClr)       idPtr <= '0;
      else if (ctl.idInc)  idPtr <= idPtr + 2'd1;
    end
  end

  assign ioOe = !ceN && !reN;
  always_comb begin
    case (ctl.outMode)
      OUT_STAT: ioOut = ctl.status;
      OUT_ID:   ioOut = ID_CODE[8*(3-int'(idPtr)) +: 8];
      default:  ioOut = (32'(colPtr) < PAGE_BYTES) ? pageReg[PW'(colPtr)] : 8'hFF;
    endcase
  end

  // R4: a program write only clears bits of the old array byte
  p_prog_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.xProg |=> (mem[$past(memAddr)] & ~$past(memQ)) == 8'h00);
  // R5: an erase write leaves 0xFF behind
  p_erase_ff_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.xErase |=> mem[$past(memAddr)] == 8'hFF);
  // R11: read positions do not move while chip enable is high
  p_ce_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> ($stable(colPtr) && $stable(idPtr)));
endmodule

// File: rtl/nand_emu.sv
module nand_emu
  import nand_pkg::*;
#(
  parameter int          PAGE_DATA       = 12,
  parameter int          PAGE_SPARE      = 4,
  parameter int          PAGES_PER_BLOCK = 4,
  parameter int          BLOCKS          = 4,
  parameter int          READ_CYCLES     = 20,
  parameter int          PROG_CYCLES     = 40,
  parameter int          ERASE_CYCLES    = 80,
  parameter logic [31:0] ID_CODE         = 32'hC25A0115
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       cleIn,
  input  logic       aleIn,
  input  logic       weN,
  input  logic       reN,
  input  logic       wpN,
  input  logic [7:0] ioIn,
  output logic [7:0] ioOut,
  output logic       ioOe,
  output logic       rbN
);
  localparam int PAGE_BYTES  = PAGE_DATA + PAGE_SPARE;
  localparam int PAGES       = PAGES_PER_BLOCK * BLOCKS;
  localparam int BLOCK_BYTES = PAGES_PER_BLOCK * PAGE_BYTES;

  dpCtl_t ctl;
  logic   busy;

  nand_ctrl #(
    .PAGE_BYTES(PAGE_BYTES), .BLOCK_BYTES(BLOCK_BYTES),
    .READ_CYCLES(READ_CYCLES), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cleIn(cleIn), .aleIn(aleIn),
    .weN(weN), .reN(reN), .wpN(wpN), .ioIn(ioIn), .ctl(ctl), .busy(busy)
  );

  nand_dp #(
    .PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES),
    .PAGES_PER_BLOCK(PAGES_PER_BLOCK), .ID_CODE(ID_CODE)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ceN(ceN), .reN(reN), .ioIn(ioIn),
    .ctl(ctl), .ioOut(ioOut), .ioOe(ioOe)
  );

  assign rbN = !busy;
endmodule

// File: tb/test_nand_emu.sv
module test_nand_emu;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ceN = 1'b0, cleIn = 1'b0, aleIn = 1'b0, weN = 1'b1, reN = 1'b1, wpN = 1'b1;
  logic [7:0] ioIn = 8'h00;
  logic [7:0] ioOut;
  logic       ioOe, rbN;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  nand_emu i_nand_emu (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cleIn(cleIn), .aleIn(aleIn), .weN(weN),
    .reN(reN), .wpN(wpN), .ioIn(ioIn), .ioOut(ioOut), .ioOe(ioOe), .rbN(rbN)
  );

  // {row, column, byte programmed, byte expected on read-back}
  localparam logic [31:0] VEC [5] = '{
    {8'd2, 8'd0,  8'hA5, 8'hA5},
    {8'd2, 8'd0,  8'h3C, 8'h24},
    {8'd5, 8'd15, 8'h0F, 8'h0F},
    {8'd5, 8'd15, 8'hF0, 8'h00},
    {8'd9, 8'd7,  8'h81, 8'h81}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk); cleIn = c; aleIn = a; ioIn = b; weN = 1'b0;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); cleIn = 1'b0; aleIn = 1'b0;
  endtask
  task automatic cmd(input logic [7:0] b);  strobe(1'b1, 1'b0, b); endtask
  task automatic adr(input logic [7:0] b);  strobe(1'b0, 1'b1, b); endtask
  task automatic din(input logic [7:0] b);  strobe(1'b0, 1'b0, b); endtask
  task automatic addr4(input logic [7:0] row, input logic [7:0] col);
    adr(col); adr(8'h00); adr(row); adr(8'h00);
  endtask

  task automatic readByte(output logic [7:0] v);
    @(negedge clk); reN = 1'b0;
    @(negedge clk); v = ioOut; reN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitReady(output int n);
    n = 0;
    while (rbN == 1'b0 && n < 100000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic progByte(input logic [7:0] row, input logic [7:0] col,
                          input logic [7:0] d, output int n);
    cmd(8'h80); addr4(row, col); din(d); cmd(8'h10); waitReady(n);
  endtask

  task automatic readAt(input logic [7:0] row, input logic [7:0] col, output logic [7:0] v);
    int n;
    cmd(8'h00); addr4(row, col); cmd(8'h30); waitReady(n); readByte(v);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check("R6 rbN after reset", {7'd0, rbN}, 8'h01);
    check("R11 ioOe idle", {7'd0, ioOe}, 8'h00);
    cmd(8'h70); readByte(v);
    check("R7 status after reset", v, 8'hC0);

    // vector table: program one byte, read it back (R1 R3 R4)
    foreach (VEC[k]) begin
      progByte(VEC[k][31:24], VEC[k][23:16], VEC[k][15:8], n);
      check("R6 program busy length", 8'(n), 8'd40);
      readAt(VEC[k][31:24], VEC[k][23:16], v);
      check("R4 program AND / R3 read", v, VEC[k][7:0]);
    end

    // R3: column past the page reads 0xFF
    readAt(8'd2, 8'd16, v);
    check("R3 column past page", v, 8'hFF);

    // R9: identification bytes
    cmd(8'h90);
    readByte(v); check("R9 id byte0", v, 8'hC2);
    readByte(v); check("R9 id byte1", v, 8'h5A);
    readByte(v); check("R9 id byte2", v, 8'h01);
    readByte(v); check("R9 id byte3", v, 8'h15);

    // R5 R7 R8: erase block of row 9, status and ignored command while busy
    cmd(8'h60); adr(8'd9); adr(8'h00); cmd(8'hD0);
    check("R6 busy after erase confirm", {7'd0, rbN}, 8'h00);
    cmd(8'h70); readByte(v);
    check("R7 status while busy", v, 8'h80);
    cmd(8'h90);
    waitReady(n);
    readByte(v);
    check("R8 id command ignored while busy", v, 8'hC0);
    readAt(8'd9, 8'd7, v);
    check("R5 erased byte", v, 8'hFF);
    readAt(8'd2, 8'd0, v);
    check("R5 other block kept", v, 8'h24);

    // R10: write protect refuses program
    wpN = 1'b0;
    cmd(8'h80); addr4(8'd2, 8'd1); din(8'h00); cmd(8'h10);
    check("R10 no busy when protected", {7'd0, rbN}, 8'h01);
    cmd(8'h70); readByte(v);
    check("R10 R7 status fail", v, 8'h41);
    wpN = 1'b1;
    readAt(8'd2, 8'd1, v);
    check("R10 array unchanged", v, 8'hFF);

    // R4 multi-byte program, fail bit cleared
    cmd(8'h80); addr4(8'd3, 8'd0); din(8'h11); din(8'h22); cmd(8'h10); waitReady(n);
    cmd(8'h70); readByte(v);
    check("R10 fail cleared by accepted program", v, 8'hC0);

    // R11: chip enable released in the middle of a read-out
    cmd(8'h00); addr4(8'd3, 8'd0); cmd(8'h30); waitReady(n);
    check("R6 read busy length", 8'(n), 8'd20);
    readByte(v); check("R11 first byte", v, 8'h11);
    @(negedge clk); ceN = 1'b1;
    @(negedge clk); reN = 1'b0;
    @(negedge clk); check("R11 ioOe off with ceN high", {7'd0, ioOe}, 8'h00); reN = 1'b1;
    @(negedge clk); ceN = 1'b0;
    readByte(v); check("R11 read position kept", v, 8'h22);
    readByte(v); check("R11 next column", v, 8'hFF);

    // R12: copy-back page 3 to page 12
    cmd(8'h00); addr4(8'd3, 8'd0); cmd(8'h35); waitReady(n);
    readByte(v); check("R12 read-out after copy-back read", v, 8'h11);
    cmd(8'h85); addr4(8'd12, 8'd0); cmd(8'h10); waitReady(n);
    readAt(8'd12, 8'd1, v);
    check("R12 copied byte", v, 8'h22);

    // R2: extra address byte ignored
    cmd(8'h80); addr4(8'd6, 8'd2); adr(8'd7); din(8'h5A); cmd(8'h10); waitReady(n);
    readAt(8'd6, 8'd2, v);
    check("R2 R1 programmed row", v, 8'h5A);
    readAt(8'd7, 8'd2, v);
    check("R2 extra byte did not move row", v, 8'hFF);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule